// File: doc/BRIEF.md
# Equalizer Power, Mute and Bypass State Controller

This block decides in which of four operating conditions a cable-equalizer signal path runs: powered off on request, asleep for lack of signal, waking up, or running. It takes an energy-detect flag from the analog front end, a cable-length estimate in metres, and control fields that arrive as plain inputs: a two-bit sleep mode, a five-bit digital mute threshold, a mute request, a bypass request, a mute-on-no-carrier enable and an acquisition-restart pulse. From these it produces a registered carrier-lost flag, a power-down enable for the analog path, a mute-force signal, a bypass enable, a ready flag, and a data output that is forced to all ones while muted.

The controller is a four-state machine. ST_OFF is forced power-down. ST_SLEEP is the automatic power-down. ST_WAKE means powered but not yet settled: muted and not bypassed. ST_RUN is normal operation. The transitions are: any state to ST_OFF when the sleep mode is 10. ST_OFF to ST_WAKE when that mode is released. Any other state to ST_WAKE on an acquisition restart. ST_SLEEP to ST_WAKE on the first cycle of carrier, or when auto sleep is turned off. ST_WAKE to ST_RUN after WAKE_CYC consecutive carrier cycles. ST_WAKE or ST_RUN to ST_SLEEP after SLEEP_CYC consecutive carrier-lost cycles in auto mode. Two dwell counters supply these delays, and each restarts as soon as its condition breaks. The defaults correspond to 190 µs and 5 ms at a 100 MHz clock.

Priority is fixed: power-down outranks mute, and mute outranks bypass.

Top module: `eq_state_ctrl`

## Requirements
- R1: Reset puts the block in ST_WAKE with cd_lost=1, pwr_down=0, mute_force=1, bypass_en=0, link_ready=0.
- R2: cd_lost is registered one cycle after its inputs and equals (energy_ok==0) OR (mute_code!=31 AND cable_len >= (mute_code+1)*STEP_M). With STEP_M=10, code 0 trips at 10 m and code 15 trips at 160 m.
- R3: sleep_mode encodings are 00 never sleep, 01 auto sleep, 10 forced power-down, and 11 behaves as 00. Mode 10 asserts pwr_down one cycle later whatever the carrier. Under 00 or 11 pwr_down is low on the next cycle.
- R4: In mode 01, pwr_down rises on the edge at which cd_lost has been high for SLEEP_CYC consecutive sampled cycles. That is SLEEP_CYC+1 clock edges after energy is lost. A carrier gap restarts the count.
- R5: From ST_SLEEP, pwr_down falls on the second edge after carrier returns. link_ready rises WAKE_CYC+1 edges after carrier returns, and any carrier loss in between restarts that count.
- R6: While pwr_down=1 or link_ready=0, mute_force=1 and bypass_en=0. In ST_RUN, bypass_en = bypass_req AND NOT mute_force.
- R7: data_out is all ones while mute_force=1; otherwise it equals data_in.
- R8: An acq_restart pulse sends the block to ST_WAKE on the next edge. link_ready then returns WAKE_CYC+1 edges after the pulse was applied.
- R9: In ST_RUN, mute_force = mute_req OR (mute_on_nocd AND cd_lost).
- R10: Leaving forced power-down enters ST_WAKE on the next edge, and link_ready rises WAKE_CYC+1 edges after the mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| energy_ok | input | 1 | Energy detector reports signal present |
| cable_len | input | LEN_W | Cable length estimate in metres |
| mute_code | input | 5 | Digital mute threshold code; 31 disables |
| sleep_mode | input | 2 | 00 never, 01 auto, 10 forced, 11 as 00 |
| mute_req | input | 1 | Manual mute request |
| bypass_req | input | 1 | Equalization bypass request |
| mute_on_nocd | input | 1 | Mute automatically when carrier is lost |
| acq_restart | input | 1 | One-cycle pulse restarting acquisition |
| data_in | input | DATA_W | Data from the equalized path |
| cd_lost | output | 1 | High when no valid carrier |
| pwr_down | output | 1 | Power-down enable for the analog path |
| mute_force | output | 1 | Output mute in force |
| bypass_en | output | 1 | Equalizer bypass enable |
| link_ready | output | 1 | Path settled and running |
| data_out | output | DATA_W | Data after muting |

## Verification
The threshold check walks cable lengths just below and at the trip point for codes 0 and 15, and then a maximal length with code 31. This separates an off-by-one compare and a wrong step from a disable that does not work. Carrier-loss runs that are broken one cycle short of the sleep delay, and wake-ups broken midway, show that both counters restart rather than accumulate. Exact edge counts for sleep, wake, restart and forced exit expose any extra or missing pipeline stage. The same long loss is applied under modes 00 and 11, to show these modes never sleep, and mute and bypass are requested together during sleep and during running to pin down the precedence.

// File: rtl/eq_state_pkg.sv
package eq_state_pkg;

    typedef enum logic [1:0] {
        ST_WAKE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_SLEEP = 2'd2,
        ST_OFF   = 2'd3
    } ctl_state_t;

    localparam logic [1:0] SLP_NEVER = 2'b00;
    localparam logic [1:0] SLP_AUTO  = 2'b01;
    localparam logic [1:0] SLP_FORCE = 2'b10;

    localparam int CODE_W = 5;

endpackage

// File: rtl/carrier_eval.sv
module carrier_eval #(
    parameter int LEN_W  = 9,
    parameter int CODE_W = 5,
    parameter int STEP_M = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              energy_ok,
    input  logic [LEN_W-1:0]  cable_len,
    input  logic [CODE_W-1:0] mute_code,
    output logic              cd_lost
);
    logic [31:0] trip_len;
    logic        code_off;
    logic        len_hit;

    always_comb begin
        trip_len = (32'(mute_code) + 32'd1) * 32'(STEP_M);
        code_off = &mute_code;
        len_hit  = !code_off && (32'(cable_len) >= trip_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cd_lost <= 1'b1;
        else        cd_lost <= !energy_ok || len_hit;
    end

    AST_NO_ENERGY_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        !energy_ok |=> cd_lost) else $error("no energy without carrier loss"); // R2

endmodule

// File: rtl/dwell_timer.sv
module dwell_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic clr,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (clr || !cond)    cnt <= '0;
        else if (cnt != LAST)     cnt <= cnt + 1'b1;
    end

    assign done = cond && !clr && (cnt == LAST);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST) else $error("dwell count past limit"); // R4

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> cnt == '0) else $error("dwell count not restarted"); // R5

endmodule

// File: rtl/eq_state_ctrl.sv
module eq_state_ctrl
    import eq_state_pkg::*;
#(
    parameter int LEN_W     = 9,
    parameter int STEP_M    = 10,
    parameter int DATA_W    = 4,
    parameter int SLEEP_CYC = 19000,
    parameter int WAKE_CYC  = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              energy_ok,
    input  logic [LEN_W-1:0]  cable_len,
    input  logic [4:0]        mute_code,
    input  logic [1:0]        sleep_mode,
    input  logic              mute_req,
    input  logic              bypass_req,
    input  logic              mute_on_nocd,
    input  logic              acq_restart,
    input  logic [DATA_W-1:0] data_in,
    output logic              cd_lost,
    output logic              pwr_down,
    output logic              mute_force,
    output logic              bypass_en,
    output logic              link_ready,
    output logic [DATA_W-1:0] data_out
);
    ctl_state_t state, state_nx;
    logic       auto_on, force_on;
    logic       loss_done, pres_done;
    logic       pres_clr;

    assign auto_on  = (sleep_mode == SLP_AUTO);
    assign force_on = (sleep_mode == SLP_FORCE);
    assign pres_clr = acq_restart || (state == ST_OFF);

    carrier_eval #(.LEN_W(LEN_W), .CODE_W(CODE_W), .STEP_M(STEP_M)) u_cd (
        .clk(clk), .rst_n(rst_n), .energy_ok(energy_ok),
        .cable_len(cable_len), .mute_code(mute_code), .cd_lost(cd_lost)
    );

    dwell_timer #(.LIMIT(SLEEP_CYC)) u_loss (
        .clk(clk), .rst_n(rst_n), .cond(cd_lost), .clr(1'b0), .done(loss_done)
    );

    dwell_timer #(.LIMIT(WAKE_CYC)) u_pres (
        .clk(clk), .rst_n(rst_n), .cond(!cd_lost), .clr(pres_clr), .done(pres_done)
    );

    always_comb begin
        state_nx = state;
        if (force_on) begin
            state_nx = ST_OFF;
        end else if (acq_restart) begin
            state_nx = ST_WAKE;
        end else begin
            unique case (state)
                ST_OFF:   state_nx = ST_WAKE;
                ST_SLEEP: if (!auto_on || !cd_lost) state_nx = ST_WAKE;
                ST_WAKE: begin
                    if (auto_on && loss_done) state_nx = ST_SLEEP;
                    else if (pres_done)       state_nx = ST_RUN;
                end
                ST_RUN:   if (auto_on && loss_done) state_nx = ST_SLEEP;
                default:  state_nx = ST_WAKE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAKE;
        else        state <= state_nx;
    end

    always_comb begin
        pwr_down   = 1'b0;
        mute_force = 1'b1;
        bypass_en  = 1'b0;
        link_ready = 1'b0;
        unique case (state)
            ST_OFF, ST_SLEEP: pwr_down = 1'b1;
            ST_WAKE: ;
            ST_RUN: begin
                link_ready = 1'b1;
                mute_force = mute_req || (mute_on_nocd && cd_lost);
                bypass_en  = bypass_req && !(mute_req || (mute_on_nocd && cd_lost));
            end
            default: ;
        endcase
        data_out = mute_force ? {DATA_W{1'b1}} : data_in;
    end

    AST_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        force_on |=> pwr_down) else $error("forced mode not powered down"); // R3

    AST_NEVER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_mode == 2'b00 || sleep_mode == 2'b11) |=> !pwr_down)
        else $error("powered down in never-sleep mode"); // R3

    AST_MUTE_OVER_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_en |-> !mute_force && !pwr_down) else $error("bypass while muted"); // R6

    AST_READY_NEEDS_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_ready) |-> $past(!cd_lost)) else $error("ready without carrier"); // R5

    AST_RESTART_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_restart && !force_on) |=> (!link_ready && !pwr_down))
        else $error("restart did not enter wake"); // R8

    AST_MUTED_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> data_out == {DATA_W{1'b1}}) else $error("data not held while down"); // R7

endmodule

// File: tb/sim_eq_state_ctrl.sv
`timescale 1ns/1ps
module sim_eq_state_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W  = 9;
    localparam int DATA_W = 4;
    localparam int SLP    = 20;
    localparam int WK     = 30;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              energy_ok;
    logic [LEN_W-1:0]  cable_len;
    logic [4:0]        mute_code;
    logic [1:0]        sleep_mode;
    logic              mute_req, bypass_req, mute_on_nocd, acq_restart;
    logic [DATA_W-1:0] data_in;
    logic              cd_lost, pwr_down, mute_force, bypass_en, link_ready;
    logic [DATA_W-1:0] data_out;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eq_state_ctrl #(.LEN_W(LEN_W), .STEP_M(10), .DATA_W(DATA_W),
                    .SLEEP_CYC(SLP), .WAKE_CYC(WK)) u0 (
        .clk(clk), .rst_n(rst_n), .energy_ok(energy_ok), .cable_len(cable_len),
        .mute_code(mute_code), .sleep_mode(sleep_mode), .mute_req(mute_req),
        .bypass_req(bypass_req), .mute_on_nocd(mute_on_nocd), .acq_restart(acq_restart),
        .data_in(data_in), .cd_lost(cd_lost), .pwr_down(pwr_down),
        .mute_force(mute_force), .bypass_en(bypass_en), .link_ready(link_ready),
        .data_out(data_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; energy_ok = 1'b1; cable_len = '0; mute_code = 5'd31;
        sleep_mode = 2'b00; mute_req = 0; bypass_req = 0; mute_on_nocd = 0;
        acq_restart = 0; data_in = 4'h5;
        edges(3);
        rst_n = 1'b1;
        chk("R1 cd_lost", cd_lost, 1);
        chk("R1 pwr_down", pwr_down, 0);
        chk("R1 mute_force", mute_force, 1);
        chk("R1 bypass_en", bypass_en, 0);
        chk("R1 link_ready", link_ready, 0);
        chk("R7 data held", data_out, 4'hF);
        edges(WK);
        chk("R5 not ready early", link_ready, 0);
        edges(1);
        chk("R5 ready after wake", link_ready, 1);
    endtask

    task automatic t_datapath;
        data_in = 4'h6; edges(1);
        chk("R7 pass-through", data_out, 4'h6);
        chk("R6 no mute running", mute_force, 0);
        bypass_req = 1; edges(1);
        chk("R6 bypass alone", bypass_en, 1);
        mute_req = 1; edges(1);
        chk("R6 mute beats bypass", bypass_en, 0);
        chk("R9 manual mute", mute_force, 1);
        chk("R7 muted data ones", data_out, 4'hF);
        mute_req = 0; bypass_req = 0; edges(1);
    endtask

    task automatic t_threshold;
        mute_code = 5'd0; cable_len = 9'd9; edges(1);
        chk("R2 code0 len9", cd_lost, 0);
        cable_len = 9'd10; edges(1);
        chk("R2 code0 len10", cd_lost, 1);
        mute_code = 5'd15; cable_len = 9'd159; edges(1);
        chk("R2 code15 len159", cd_lost, 0);
        cable_len = 9'd160; edges(1);
        chk("R2 code15 len160", cd_lost, 1);
        mute_code = 5'd31; cable_len = 9'd511; edges(1);
        chk("R2 code31 never", cd_lost, 0);
        energy_ok = 0; edges(1);
        chk("R2 no energy", cd_lost, 1);
        energy_ok = 1; cable_len = '0; edges(1);
        chk("R2 energy back", cd_lost, 0);
    endtask

    task automatic t_mute_nocd;
        mute_on_nocd = 0; energy_ok = 0; edges(1);
        chk("R9 no auto mute when disabled", mute_force, 0);
        mute_on_nocd = 1; edges(1);
        chk("R9 mute on no carrier", mute_force, 1);
        energy_ok = 1; edges(1);
        chk("R9 unmute on carrier", mute_force, 0);
        mute_on_nocd = 0;
    endtask

    task automatic t_never_sleep;
        sleep_mode = 2'b00; energy_ok = 0; edges(3*SLP);
        chk("R3 mode00 no sleep", pwr_down, 0);
        sleep_mode = 2'b11; edges(3*SLP);
        chk("R3 mode11 no sleep", pwr_down, 0);
        chk("R3 still running", link_ready, 1);
        energy_ok = 1; sleep_mode = 2'b00; edges(2);
    endtask

    task automatic t_auto_sleep;
        sleep_mode = 2'b01; bypass_req = 1;
        energy_ok = 0; edges(SLP - 5);
        energy_ok = 1; edges(2);
        chk("R4 broken loss no sleep", pwr_down, 0);
        energy_ok = 0; edges(SLP);
        chk("R4 awake before delay", pwr_down, 0);
        edges(1);
        chk("R4 asleep at delay", pwr_down, 1);
        chk("R6 sleep mutes", mute_force, 1);
        chk("R6 sleep no bypass", bypass_en, 0);
        chk("R7 sleep data ones", data_out, 4'hF);
        bypass_req = 0;
    endtask

    task automatic t_wake;
        energy_ok = 1; edges(1);
        chk("R5 still down one edge", pwr_down, 1);
        edges(1);
        chk("R5 powered on", pwr_down, 0);
        chk("R6 waking muted", mute_force, 1);
        edges(8);
        energy_ok = 0; edges(1);
        energy_ok = 1; edges(WK);
        chk("R5 wake restarted", link_ready, 0);
        edges(1);
        chk("R5 ready after restart", link_ready, 1);
    endtask

    task automatic t_forced;
        sleep_mode = 2'b10; edges(1);
        chk("R3 forced down", pwr_down, 1);
        edges(5);
        chk("R3 forced holds", pwr_down, 1);
        sleep_mode = 2'b00; edges(1);
        chk("R10 exit to wake", pwr_down, 0);
        chk("R10 not ready", link_ready, 0);
        edges(WK - 1);
        chk("R10 still waking", link_ready, 0);
        edges(1);
        chk("R10 ready", link_ready, 1);
    endtask

    task automatic t_restart;
        acq_restart = 1; edges(1);
        acq_restart = 0;
        chk("R8 back to wake", link_ready, 0);
        chk("R8 muted in wake", mute_force, 1);
        edges(WK - 1);
        chk("R8 still waking", link_ready, 0);
        edges(1);
        chk("R8 ready again", link_ready, 1);
    endtask

    initial begin
        t_reset;
        t_datapath;
        t_threshold;
        t_mute_nocd;
        t_never_sleep;
        t_auto_sleep;
        t_wake;
        sleep_mode = 2'b00;
        t_forced;
        t_restart;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule